// File: doc/BRIEF.md
# Two-Level Overcurrent Fault Latch

This block sits behind a pair of current-sense comparators in a buck converter controller. One comparator flags a moderate overcurrent (a sense differential of about 20 mV) and the other flags a severe one (about 30 mV). The controller looks at both flags once per switching cycle, on a one-clock cycle tick. A severe flag turns the power stage off at once. Moderate flags are counted, and the converter is shut down only when four switching cycles in a row show one. A cycle without a moderate flag clears the count.

Once a trip occurs, the block holds the shutdown and reports the cause until the control supply's power-on reset is applied. Dropping and raising the enable input turns the converter off and on again, but it never clears a held fault. The shutdown request is one signal that means both power switches are off. It comes from a combinational path, so a trip cuts the gates in the same clock cycle as the tick that caused it.

Top module: `ocp_two_level_latch`

## Requirements
- R1: After `por_n` is released, `fault_latched` is 0, `fault_kind` is 2'b00, and `gate_off` equals the inverse of `enable`.
- R2: While `enable` is 0, `gate_off` is 1 and no trip can occur. Dropping `enable` throws away any partial count of moderate events.
- R3: A cycle tick with `enable`=1 and `over_hi`=1 raises `gate_off` in that same clock cycle. At the next edge it sets `fault_latched`=1 and `fault_kind`=2'b10.
- R4: Each cycle tick with `over_lo`=1 counts one moderate event. The fourth consecutive counted tick raises `gate_off` in that same clock cycle. At the next edge it sets `fault_latched`=1 and `fault_kind`=2'b01.
- R5: A cycle tick with `over_lo`=0 clears the count. Three events, one clean tick, then three more events do not trip.
- R6: Flag values in clock cycles without a cycle tick are ignored. Clean clocks between ticks do not clear the count.
- R7: Once latched, `gate_off` stays 1 and the cause stays unchanged under any `enable` or flag activity. Only `por_n`=0 clears the latch.
- R8: If a severe flag and the fourth moderate event arrive on the same tick, the cause is recorded as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset of the control supply, active low, asynchronous |
| enable | input | 1 | Converter run request |
| cycle_tick | input | 1 | One-clock pulse marking the flag sampling point of each switching cycle |
| over_lo | input | 1 | Moderate overcurrent comparator flag |
| over_hi | input | 1 | Severe overcurrent comparator flag |
| gate_off | output | 1 | Shutdown request: both power switches off |
| fault_latched | output | 1 | A trip is being held |
| fault_kind | output | 2 | Cause of the held trip: 00 none, 01 repeated moderate, 10 severe |

## Verification
The severe-flag trip and the fourth moderate event can land on the same cycle tick. The bench provokes this by driving three moderate ticks and then a tick carrying both flags. It then checks that `gate_off` is already high before the clock edge and that the recorded cause is the severe one. A reference model in the bench, written from the requirements, predicts `gate_off`, the latch and the cause for every driven cycle. Further sequences cover a clean tick that breaks a run at three events, ticks spread across idle clocks, and enable toggling on either side of a trip.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    FK_NONE   = 2'b00,
    FK_REPEAT = 2'b01,
    FK_HIGH   = 2'b10
  } fault_kind_e;

  // Next value of the moderate-event run length after one sampled tick.
  function automatic int unsigned ocp_next_count(int unsigned cur,
                                                 int unsigned top_val,
                                                 logic        event_seen);
    if (!event_seen) return 0;
    if (cur >= top_val) return top_val;
    return cur + 1;
  endfunction

  // True when one more event on top of cur reaches the trip limit.
  function automatic logic ocp_is_final(int unsigned cur, int unsigned limit);
    return (cur + 1) >= limit;
  endfunction

endpackage

// File: rtl/ocp_event_counter.sv
module ocp_event_counter #(
  parameter int LIMIT = 4,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic clear,
  input  logic sample,
  input  logic over_lo,
  output logic final_event
);
  import ocp_pkg::*;

  localparam int unsigned TOPV = unsigned'(LIMIT - 1);

  logic [CNT_W-1:0] count;
  logic [31:0]      count_ext;

  assign count_ext   = {{(32-CNT_W){1'b0}}, count};
  assign final_event = sample & over_lo & ocp_is_final(count_ext, unsigned'(LIMIT));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (sample) begin
      count <= CNT_W'(ocp_next_count(count_ext, TOPV, over_lo));
    end
  end

  // R4: the run length never passes the value one below the limit
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!por_n)
    count_ext <= TOPV);

  // R4: a counted event below the limit advances the run by one
  p_count_step_r4: assert property (@(posedge clk) disable iff (!por_n)
    (sample && over_lo && !clear && count_ext < TOPV) |=> (count == $past(count) + 1'b1));

  // R5: a clean sampled tick empties the run
  p_clean_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
    (sample && !over_lo && !clear) |=> (count == '0));

  // R6: without a sample or clear the run is held
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!sample && !clear) |=> $stable(count));

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch (
  input  logic                clk,
  input  logic                por_n,
  input  logic                trip_high,
  input  logic                trip_repeat,
  output logic                latched,
  output ocp_pkg::fault_kind_e kind
);
  import ocp_pkg::*;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      latched <= 1'b0;
      kind    <= FK_NONE;
    end else if (!latched) begin
      if (trip_high) begin
        latched <= 1'b1;
        kind    <= FK_HIGH;
      end else if (trip_repeat) begin
        latched <= 1'b1;
        kind    <= FK_REPEAT;
      end
    end
  end

  // R7: a held trip and its cause never change until power-on reset
  p_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    latched |=> (latched && $stable(kind)));

  // R8: the severe cause wins over a coincident repeat trip
  p_high_wins_r8: assert property (@(posedge clk) disable iff (!por_n)
    (trip_high && !latched) |=> (kind == FK_HIGH));

  // R1: a cause is reported exactly when a trip is held
  p_kind_consistent_r1: assert property (@(posedge clk) disable iff (!por_n)
    latched == (kind != FK_NONE));

endmodule

// File: rtl/ocp_two_level_latch.sv
module ocp_two_level_latch #(
  parameter int REPEAT_LIMIT = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       enable,
  input  logic       cycle_tick,
  input  logic       over_lo,
  input  logic       over_hi,
  output logic       gate_off,
  output logic       fault_latched,
  output logic [1:0] fault_kind
);
  import ocp_pkg::*;

  localparam int CNT_W = (REPEAT_LIMIT < 2) ? 1 : $clog2(REPEAT_LIMIT);

  // Named internal events, brought out for the checks below
  logic        live;
  logic        sample;
  logic        trip_high;
  logic        trip_repeat;
  fault_kind_e kind_w;

  assign live      = enable & ~fault_latched;
  assign sample    = cycle_tick & live;
  assign trip_high = sample & over_hi;

  ocp_event_counter #(
    .LIMIT (REPEAT_LIMIT),
    .CNT_W (CNT_W)
  ) u_count (
    .clk         (clk),
    .por_n       (por_n),
    .clear       (~live),
    .sample      (sample),
    .over_lo     (over_lo),
    .final_event (trip_repeat)
  );

  ocp_fault_latch u_latch (
    .clk         (clk),
    .por_n       (por_n),
    .trip_high   (trip_high),
    .trip_repeat (trip_repeat),
    .latched     (fault_latched),
    .kind        (kind_w)
  );

  assign fault_kind = kind_w;
  assign gate_off   = fault_latched | ~enable | trip_high | trip_repeat;

  // R3: a severe flag on a live tick cuts the gates in the same cycle
  p_hi_immediate_r3: assert property (@(posedge clk) disable iff (!por_n)
    (cycle_tick && enable && over_hi) |-> gate_off);

  // R3: and the trip is held from the next edge on
  p_hi_latches_r3: assert property (@(posedge clk) disable iff (!por_n)
    (cycle_tick && enable && over_hi) |=> fault_latched);

  // R2: with enable low nothing new is latched
  p_disabled_no_trip_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!enable && !fault_latched) |=> !fault_latched);

  // R6: a clock without a tick cannot start a trip
  p_no_tick_no_trip_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!cycle_tick && !fault_latched) |=> !fault_latched);

  // R7: while held, the shutdown request stays asserted
  p_held_off_r7: assert property (@(posedge clk) disable iff (!por_n)
    fault_latched |-> gate_off);

endmodule

// File: tb/ocp_two_level_latch_tb.sv
`timescale 1ns/100ps
module ocp_two_level_latch_tb;

  localparam int LIM = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       enable = 1'b0;
  logic       cycle_tick = 1'b0;
  logic       over_lo = 1'b0;
  logic       over_hi = 1'b0;
  logic       gate_off;
  logic       fault_latched;
  logic [1:0] fault_kind;

  always #4 clk = ~clk;

  ocp_two_level_latch #(.REPEAT_LIMIT(LIM)) u_dut (
    .clk           (clk),
    .por_n         (por_n),
    .enable        (enable),
    .cycle_tick    (cycle_tick),
    .over_lo       (over_lo),
    .over_hi       (over_hi),
    .gate_off      (gate_off),
    .fault_latched (fault_latched),
    .fault_kind    (fault_kind)
  );

  typedef struct {
    logic       gate_now;
    logic       lat_next;
    logic [1:0] kind_next;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;

  // Bench reference state, derived from the requirements
  int         m_run = 0;
  logic       m_lat = 1'b0;
  logic [1:0] m_kind = 2'b00;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one clock of stimulus and queues what must be seen
  task automatic step(logic en, logic tk, logic lo, logic hi, string tag);
    exp_t it;
    logic ok, hit_hi, hit_rep;
    @(posedge clk); #1;
    enable = en; cycle_tick = tk; over_lo = lo; over_hi = hi;
    ok      = en && !m_lat;
    hit_hi  = tk && ok && hi;
    hit_rep = tk && ok && lo && (m_run == LIM - 1);
    it.gate_now = m_lat || !en || hit_hi || hit_rep;
    if (!m_lat) begin
      if (hit_hi) begin m_lat = 1'b1; m_kind = 2'b10; end
      else if (hit_rep) begin m_lat = 1'b1; m_kind = 2'b01; end
    end
    if (!ok) m_run = 0;
    else if (tk) m_run = lo ? ((m_run < LIM - 1) ? m_run + 1 : m_run) : 0;
    it.lat_next  = m_lat;
    it.kind_next = m_kind;
    it.tag       = tag;
    q.push_back(it);
  endtask

  task automatic power_cycle();
    @(posedge clk); #1;
    por_n = 1'b0; enable = 1'b0; cycle_tick = 1'b0; over_lo = 1'b0; over_hi = 1'b0;
    m_run = 0; m_lat = 1'b0; m_kind = 2'b00;
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;
  endtask

  // Monitor: pops each expectation and compares mid-cycle and after the edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(it.tag, "gate_off", int'(gate_off), int'(it.gate_now));
        @(posedge clk); #0.5;
        chk(it.tag, "fault_latched", int'(fault_latched), int'(it.lat_next));
        chk(it.tag, "fault_kind", int'(fault_kind), int'(it.kind_next));
      end
    end
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    power_cycle();
    // R1: reset state, disabled then enabled
    step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    // R4: four consecutive moderate ticks, last trips at once
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R4");

    // R5: three events, clean tick, three events -> no trip; then one more trips
    power_cycle();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R4");

    // R6: flags without a tick are ignored; idle clocks keep the run
    power_cycle();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R6");
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    end
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6");

    // R3: single severe tick
    power_cycle();
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R3");
    // R7: enable toggling and further flags leave the trip held
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    power_cycle();
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7");

    // R2: disabled ticks do nothing; dropping enable discards the run
    power_cycle();
    step(1'b0, 1'b1, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R2");

    // R8: severe flag coincides with the fourth moderate event
    power_cycle();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R8");

    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule